// File: doc/BRIEF.md
# Per-bit write delay centering engine

This engine trains the write delay of every DQ bit against the write strobe. For one bit at a time it steps a delay tap from 0 to 63. At each tap it runs a closed loop: issue a write command carrying a test byte, issue a read command to the same place, wait for the returned data, and compare the bit under test with what was sent. Taps where the readback holds for several pairs in a row form a pass window. Once the sweep of a bit ends, the engine sets that bit's delay to the middle of the longest pass window it found.

The block sits between a training sequencer, which pulses `start_i` and waits for `done_o`, and the command path to memory. The per-bit delays drive the PHY delay cells directly. They stay fixed after training until the next start.

Top module: `wr_center_engine`

## Requirements
- R1: After reset every delay field of `dq_dly_o` is RESET_TAP (default 32), and `done_o`, `err_o` and `cmd_req_o` are 0.
- R2: Each check pair is one write command followed by one read command. `cmd_req_o` and `cmd_wr_o` are held until `cmd_ack_i`. The compare waits for `rd_valid_i`, and writes and reads strictly alternate.
- R3: Write data is an 8-bit LFSR byte, x^8+x^6+x^5+x^4+1, seeded with 0xA5 on start. Each accepted write advances it with next = {q[6:0], q[7]^q[5]^q[4]^q[3]}, and the byte is replicated across the DQ width.
- R4: Only the bit under test is compared. Errors on other bits do not affect its result.
- R5: The taps of a bit are swept from 0 up to 63 in steps of one. The bit's field in `dq_dly_o` shows the current tap while it is swept.
- R6: A tap passes only after PASS_M (default 2) consecutive matching pairs. Any mismatch fails the tap.
- R7: The final tap is start + (length-1)/2, rounded down, of the longest run of consecutive passing taps. Of equal-length runs, the lowest one is used.
- R8: A bit with no passing tap sets `err_o` and keeps RESET_TAP, and the engine goes on to the next bit.
- R9: Bits are trained from bit 0 upward. `done_o` is a single-cycle pulse after the last bit, and the delays then hold until the next start.
- R10: A start in idle clears `err_o` and reloads all delays to RESET_TAP before the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a training run (accepted when idle) |
| cmd_req_o | output | 1 | Command request |
| cmd_wr_o | output | 1 | 1 = write command, 0 = read command |
| cmd_ack_i | input | 1 | Command accepted |
| wr_data_o | output | DQ_W | Write data for the write command |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | DQ_W | Read data |
| dq_dly_o | output | DQ_W*TAP_W | Per-bit write delay, bit b in [b*TAP_W +: TAP_W] |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| err_o | output | 1 | Some bit had no passing tap during the last run |

## Verification
A corrupted run tracker or tap counter does not stay hidden. It shows up as a wrong final tap in `dq_dly_o` on the cycle after that bit's sweep ends, well before `done_o`. A slip in the pair counter or the compare lane shows up at a flaky tap inside an eye, where the final centre moves by several taps. Pattern or handshake faults show up on the first write command after start: the byte differs from the LFSR sequence, or a read is issued without a write before it.

// File: rtl/wc_pkg.sv
package wc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_WR, S_RD, S_WAIT, S_EVAL, S_FIN
  } wc_state_e;
endpackage

// File: rtl/wc_lfsr.sv
module wc_lfsr #(
  parameter logic [7:0] SEED = 8'hA5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       step,
  output logic [7:0] q
);
  always_ff @(posedge clk) begin
    if (rst || load) q <= SEED;
    else if (step)   q <= {q[6:0], q[7] ^ q[5] ^ q[4] ^ q[3]};
  end

  p_lfsr_nonzero_r3: assert property (@(posedge clk) disable iff (rst) q != 8'h00)
    else $error("LFSR reached the all-zero lockup state");
endmodule

// File: rtl/wc_run_tracker.sv
module wc_run_tracker #(
  parameter int TAP_W = 6,
  localparam int LEN_W = TAP_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             upd,
  input  logic             pass,
  input  logic [TAP_W-1:0] tap,
  output logic [TAP_W-1:0] center,
  output logic             found
);
  logic [TAP_W-1:0] cur_start, best_start, nstart;
  logic [LEN_W-1:0] cur_len, best_len, nlen, half;

  assign nstart = (cur_len == '0) ? tap : cur_start;
  assign nlen   = cur_len + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cur_start  <= '0;
      cur_len    <= '0;
      best_start <= '0;
      best_len   <= '0;
    end else if (upd) begin
      if (pass) begin
        cur_start <= nstart;
        cur_len   <= nlen;
        if (nlen > best_len) begin
          best_start <= nstart;
          best_len   <= nlen;
        end
      end else begin
        cur_len <= '0;
      end
    end
  end

  assign half   = (best_len - 1'b1) >> 1;
  assign center = best_start + half[TAP_W-1:0];
  assign found  = (best_len != '0);

  p_run_bound_r7: assert property (@(posedge clk) disable iff (rst) best_len >= cur_len)
    else $error("current run longer than recorded best run");
endmodule

// File: rtl/wc_delay_regs.sv
module wc_delay_regs #(
  parameter int DQ_W = 8,
  parameter int TAP_W = 6,
  parameter logic [TAP_W-1:0] RESET_TAP = 6'd32,
  localparam int BIT_W = (DQ_W > 1) ? $clog2(DQ_W) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  we,
  input  logic [BIT_W-1:0]      waddr,
  input  logic [TAP_W-1:0]      wdata,
  output logic [DQ_W*TAP_W-1:0] dly
);
  logic [TAP_W-1:0] mem [DQ_W];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < DQ_W; i++) mem[i] <= RESET_TAP;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < DQ_W; g++) begin : g_out
    assign dly[g*TAP_W +: TAP_W] = mem[g];
  end
endmodule

// File: rtl/wr_center_engine.sv
module wr_center_engine #(
  parameter int DQ_W = 8,
  parameter int TAP_W = 6,
  parameter int PASS_M = 2,
  parameter logic [TAP_W-1:0] RESET_TAP = 6'd32,
  parameter logic [7:0] SEED = 8'hA5,
  localparam int BIT_W = (DQ_W > 1) ? $clog2(DQ_W) : 1,
  localparam int CNT_W = $clog2(PASS_M + 1),
  localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}}
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  output logic                  cmd_req_o,
  output logic                  cmd_wr_o,
  input  logic                  cmd_ack_i,
  output logic [DQ_W-1:0]       wr_data_o,
  input  logic                  rd_valid_i,
  input  logic [DQ_W-1:0]       rd_data_i,
  output logic [DQ_W*TAP_W-1:0] dq_dly_o,
  output logic                  done_o,
  output logic                  err_o
);
  import wc_pkg::*;

  wc_state_e        state;
  logic [BIT_W-1:0] bit_q;
  logic [TAP_W-1:0] tap_q;
  logic [CNT_W-1:0] pair_q;
  logic [DQ_W-1:0]  exp_q;
  logic             pass_q;
  logic [7:0]       pat;
  logic             run_go, match;
  logic             rf_we;
  logic [TAP_W-1:0] rf_wdata, trk_center;
  logic             trk_found;

  assign run_go = (state == S_IDLE) && start_i;
  assign match  = (rd_data_i[bit_q] == exp_q[bit_q]);

  wc_lfsr #(.SEED(SEED)) u_lfsr (
    .clk(clk), .rst(rst), .load(run_go),
    .step((state == S_WR) && cmd_ack_i), .q(pat)
  );

  for (genvar g = 0; g < DQ_W / 8; g++) begin : g_pat
    assign wr_data_o[g*8 +: 8] = pat;
  end

  wc_run_tracker #(.TAP_W(TAP_W)) u_trk (
    .clk(clk), .rst(rst), .clr(run_go || (state == S_FIN)),
    .upd(state == S_EVAL), .pass(pass_q), .tap(tap_q),
    .center(trk_center), .found(trk_found)
  );

  assign rf_we    = (state == S_LOAD) || (state == S_FIN);
  assign rf_wdata = (state == S_LOAD) ? tap_q : (trk_found ? trk_center : RESET_TAP);

  wc_delay_regs #(.DQ_W(DQ_W), .TAP_W(TAP_W), .RESET_TAP(RESET_TAP)) u_regs (
    .clk(clk), .rst(rst), .clr(run_go), .we(rf_we),
    .waddr(bit_q), .wdata(rf_wdata), .dly(dq_dly_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      bit_q     <= '0;
      tap_q     <= '0;
      pair_q    <= '0;
      exp_q     <= '0;
      pass_q    <= 1'b0;
      cmd_req_o <= 1'b0;
      cmd_wr_o  <= 1'b0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          bit_q <= '0;
          tap_q <= '0;
          err_o <= 1'b0;
          state <= S_LOAD;
        end
        S_LOAD: begin
          pair_q    <= '0;
          cmd_req_o <= 1'b1;
          cmd_wr_o  <= 1'b1;
          state     <= S_WR;
        end
        S_WR: if (cmd_ack_i) begin
          exp_q    <= wr_data_o;
          cmd_wr_o <= 1'b0;
          state    <= S_RD;
        end
        S_RD: if (cmd_ack_i) begin
          cmd_req_o <= 1'b0;
          state     <= S_WAIT;
        end
        S_WAIT: if (rd_valid_i) begin
          if (!match) begin
            pass_q <= 1'b0;
            state  <= S_EVAL;
          end else if (pair_q == CNT_W'(PASS_M - 1)) begin
            pass_q <= 1'b1;
            state  <= S_EVAL;
          end else begin
            pair_q    <= pair_q + 1'b1;
            cmd_req_o <= 1'b1;
            cmd_wr_o  <= 1'b1;
            state     <= S_WR;
          end
        end
        S_EVAL: begin
          if (tap_q == TAP_MAX) begin
            state <= S_FIN;
          end else begin
            tap_q <= tap_q + 1'b1;
            state <= S_LOAD;
          end
        end
        S_FIN: begin
          if (!trk_found) err_o <= 1'b1;
          if (bit_q == BIT_W'(DQ_W - 1)) begin
            done_o <= 1'b1;
            state  <= S_IDLE;
          end else begin
            bit_q <= bit_q + 1'b1;
            tap_q <= '0;
            state <= S_LOAD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_req_o && !cmd_ack_i) |=> (cmd_req_o && $stable(cmd_wr_o)))
    else $error("command request dropped or changed before acknowledge");

  p_tap_step_r5: assert property (@(posedge clk) disable iff (rst)
    (state == S_LOAD && $past(state) == S_EVAL) |-> (tap_q == $past(tap_q) + 1'b1))
    else $error("tap did not advance by one");

  p_err_keeps_reset_r8: assert property (@(posedge clk) disable iff (rst)
    (state == S_FIN && !trk_found) |=> err_o)
    else $error("empty window did not raise error");

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o)
    else $error("done held longer than one cycle");
endmodule

// File: tb/tb_wr_center_engine.sv
module tb_wr_center_engine;
  localparam int DQ_W = 8;
  localparam int TAP_W = 6;
  localparam logic [5:0] RST_TAP = 6'd32;

  typedef struct packed {
    logic [5:0] lo1, hi1, lo2, hi2, flk;
    logic       uf;
    logic [5:0] exp_tap;
  } vec_t;

  // Per-bit eye model and expected centre; empty window coded as lo>hi.
  localparam vec_t VEC [DQ_W] = '{
    '{6'd10, 6'd30, 6'd1,  6'd0,  6'd0,  1'b0, 6'd20},  // single window
    '{6'd0,  6'd63, 6'd1,  6'd0,  6'd0,  1'b0, 6'd31},  // full range
    '{6'd1,  6'd0,  6'd1,  6'd0,  6'd0,  1'b0, 6'd32},  // no pass -> error
    '{6'd5,  6'd9,  6'd40, 6'd51, 6'd0,  1'b0, 6'd45},  // longer second run
    '{6'd2,  6'd5,  6'd20, 6'd23, 6'd0,  1'b0, 6'd3 },  // tie, lowest wins
    '{6'd10, 6'd30, 6'd1,  6'd0,  6'd15, 1'b1, 6'd23},  // flaky tap splits eye
    '{6'd63, 6'd63, 6'd1,  6'd0,  6'd0,  1'b0, 6'd63},  // single top tap
    '{6'd60, 6'd63, 6'd1,  6'd0,  6'd0,  1'b0, 6'd61}   // even length, round down
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic cmd_req_o, cmd_wr_o, cmd_ack_i, rd_valid_i, done_o, err_o;
  logic [DQ_W-1:0] wr_data_o, rd_data_i;
  logic [DQ_W*TAP_W-1:0] dq_dly_o;

  always #4 clk = ~clk;

  wr_center_engine dut (
    .clk(clk), .rst(rst), .start_i(start_i),
    .cmd_req_o(cmd_req_o), .cmd_wr_o(cmd_wr_o), .cmd_ack_i(cmd_ack_i),
    .wr_data_o(wr_data_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .dq_dly_o(dq_dly_o), .done_o(done_o), .err_o(err_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [5:0] lo1 [DQ_W], hi1 [DQ_W], lo2 [DQ_W], hi2 [DQ_W], flk [DQ_W];
  logic uf [DQ_W];

  // memory model state
  logic [DQ_W-1:0] mem_q = '0;
  logic [7:0] exp_pat = 8'hA5;
  int wcnt = 0, nwr = 0, proto_err = 0, pat_err = 0;
  logic last_wr = 1'b0, first_pend = 1'b0;
  logic [DQ_W*TAP_W-1:0] first_dly = '0;

  function automatic logic [7:0] lfsr_next(input logic [7:0] x);
    return {x[6:0], x[7] ^ x[5] ^ x[4] ^ x[3]};
  endfunction

  function automatic logic [DQ_W-1:0] bad_mask(input logic [DQ_W*TAP_W-1:0] d, input int wc);
    logic [DQ_W-1:0] m;
    for (int b = 0; b < DQ_W; b++) begin
      logic [5:0] t;
      logic ok;
      t = d[b*TAP_W +: TAP_W];
      ok = (t >= lo1[b] && t <= hi1[b]) || (t >= lo2[b] && t <= hi2[b]);
      if (uf[b] && t == flk[b] && wc[0]) ok = 1'b0;
      m[b] = ~ok;
    end
    return m;
  endfunction

  initial begin
    cmd_ack_i  = 1'b0;
    rd_valid_i = 1'b0;
    rd_data_i  = '0;
    forever begin
      @(posedge clk);
      if (start_i) begin
        exp_pat <= 8'hA5;
        first_pend <= 1'b1;
        last_wr <= 1'b0;
      end
      cmd_ack_i  <= cmd_req_o && !cmd_ack_i;
      rd_valid_i <= 1'b0;
      if (cmd_ack_i && cmd_req_o && cmd_wr_o) begin
        if (last_wr) proto_err <= proto_err + 1;
        if (wr_data_o != exp_pat) pat_err <= pat_err + 1;
        exp_pat <= lfsr_next(exp_pat);
        mem_q <= wr_data_o ^ bad_mask(dq_dly_o, wcnt);
        wcnt <= wcnt + 1;
        nwr <= nwr + 1;
        last_wr <= 1'b1;
        if (first_pend) begin
          first_dly <= dq_dly_o;
          first_pend <= 1'b0;
        end
      end else if (cmd_ack_i && cmd_req_o && !cmd_wr_o) begin
        if (!last_wr) proto_err <= proto_err + 1;
        last_wr <= 1'b0;
        rd_valid_i <= 1'b1;
        rd_data_i <= mem_q;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output logic seen);
    seen = 1'b0;
    for (int i = 0; i < 30000 && !seen; i++) begin
      @(negedge clk);
      if (done_o) seen = 1'b1;
    end
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic seen;
    logic [DQ_W*TAP_W-1:0] snap;
    for (int b = 0; b < DQ_W; b++) begin
      lo1[b] = VEC[b].lo1; hi1[b] = VEC[b].hi1;
      lo2[b] = VEC[b].lo2; hi2[b] = VEC[b].hi2;
      flk[b] = VEC[b].flk; uf[b]  = VEC[b].uf;
    end
    repeat (5) @(negedge clk);
    // R1: reset state
    for (int b = 0; b < DQ_W; b++)
      chk(dq_dly_o[b*TAP_W +: TAP_W] == RST_TAP, "R1 reset delay", int'(dq_dly_o[b*TAP_W +: TAP_W]), int'(RST_TAP));
    chk(!done_o && !err_o && !cmd_req_o, "R1 reset flags", int'({done_o, err_o, cmd_req_o}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!cmd_req_o, "R1 idle without start", int'(cmd_req_o), 0);

    // Run 1: walk the vector table
    pulse_start();
    wait_done(seen);
    chk(seen, "R9 done seen", int'(seen), 1);
    @(negedge clk);
    chk(!done_o, "R9 done single cycle", int'(done_o), 0);
    for (int b = 0; b < DQ_W; b++)
      chk(dq_dly_o[b*TAP_W +: TAP_W] == VEC[b].exp_tap, $sformatf("R7 R6 R8 bit %0d centre", b),
          int'(dq_dly_o[b*TAP_W +: TAP_W]), int'(VEC[b].exp_tap));
    chk(err_o, "R8 error flag", int'(err_o), 1);
    chk(proto_err == 0 && nwr > 0, "R2 write-read alternation", proto_err, 0);
    chk(pat_err == 0, "R3 LFSR write pattern", pat_err, 0);
    chk(first_dly[0 +: TAP_W] == 6'd0, "R5 first tap of bit 0", int'(first_dly[0 +: TAP_W]), 0);
    chk(first_dly[TAP_W +: TAP_W] == RST_TAP, "R4 other bits untouched at sweep start",
        int'(first_dly[TAP_W +: TAP_W]), int'(RST_TAP));

    // R9: delays hold after done
    snap = dq_dly_o;
    repeat (40) @(negedge clk);
    chk(dq_dly_o == snap, "R9 delays held", 0, 0);
    chk(!cmd_req_o, "R9 no commands after done", int'(cmd_req_o), 0);

    // Run 2: bit 2 now has an eye 0..9 -> centre 4
    lo1[2] = 6'd0; hi1[2] = 6'd9;
    pulse_start();
    @(negedge clk);
    chk(!err_o, "R10 error cleared on start", int'(err_o), 0);
    wait_done(seen);
    chk(seen, "R9 second done seen", int'(seen), 1);
    chk(first_dly[TAP_W +: TAP_W] == RST_TAP, "R10 delays reloaded on start",
        int'(first_dly[TAP_W +: TAP_W]), int'(RST_TAP));
    chk(dq_dly_o[2*TAP_W +: TAP_W] == 6'd4, "R7 retrained bit 2",
        int'(dq_dly_o[2*TAP_W +: TAP_W]), 4);
    chk(dq_dly_o[5*TAP_W +: TAP_W] == 6'd23, "R6 flaky tap rejected again",
        int'(dq_dly_o[5*TAP_W +: TAP_W]), 23);
    chk(!err_o, "R8 no error when all bits pass", int'(err_o), 0);
    chk(pat_err == 0 && proto_err == 0, "R3 R2 second run traffic", pat_err + proto_err, 0);
    summary();
  end
endmodule